// File: doc/BRIEF.md
# User Hardware-Register Read Unit

This block answers requests from unprivileged code that wants to read a small set of machine registers directly, without a trap into the kernel. It keeps a software-writable grant register with one bit per register number. On a request carrying a register number and a select field, it decides whether the read is legal, picks the matching source value, or raises a reserved-instruction exception flag.

The grant register's writable bits depend on two static configuration inputs: whether the core implements the newer (release-6) ISA, and which optional features are present. The instruction decoder sends `req_num` and `req_sel`. In the standard 32-bit encoding, `req_sel` comes from instruction bits 8:6. The pipeline consumes the registered result one cycle later. Exception vectoring stays with the core.

Top module: `hwreg_user_read`

## Requirements
- R1: The grant register resets to zero. A write stores `gr_wdata` ANDed with a write mask, and the mask always includes bits 3:0.
- R2: Mask bit 4 is set only when `cfg_perf_present` and `isa_rev6` are both 1. Mask bit 5 is set whenever `isa_rev6` is 1.
- R3: Mask bit 29 is set only when `cfg_uloc_present` is 1. Every other grant bit always reads 0 on `gr_rdata`.
- R4: A read of an implemented register is allowed when `priv_mode` is 1, or when grant bit [`req_num`] is set. Otherwise `rsp_exc` is 1.
- R5: Register 0 returns `ebase[9:0]`, zero-extended.
- R6: Register 1 returns `line_step`. Register 3 returns `cnt_res`.
- R7: Register 2 returns `cycle_cnt`, sign-extended from bit 31 to the data width.
- R8: Register 4 returns `perf_ctl0` only when `req_sel` is 0. A nonzero select with register 4 raises `rsp_exc`, even in privileged mode. For every other register, `req_sel` has no effect.
- R9: Register 5 returns bit 13 of `cfg5_word` in bit 0, with all other bits zero.
- R10: When `isa_rev6` is 0, a request for register 4 or 5 raises `rsp_exc`.
- R11: Register 29 returns `user_local`, under the same grant check. Any register number other than 0–5 and 29 raises `rsp_exc`.
- R12: `rsp_valid` is 1 exactly in the cycle after `req_valid` is 1. `rsp_data` and `rsp_exc` are valid in that cycle. Whenever `rsp_exc` is 1, `rsp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_mode | input | 1 | Kernel or coprocessor-usable mode |
| isa_rev6 | input | 1 | Core implements the release-6 ISA |
| cfg_perf_present | input | 1 | Performance counters are present |
| cfg_uloc_present | input | 1 | User-local register is present |
| cfg5_word | input | 32 | Fifth configuration register |
| gr_wr | input | 1 | Grant register write strobe |
| gr_wdata | input | 32 | Grant register write value |
| gr_rdata | output | 32 | Grant register contents |
| ebase | input | DATA_W | Exception-base register |
| line_step | input | DATA_W | Cache-line step size |
| cycle_cnt | input | 32 | Cycle counter |
| cnt_res | input | DATA_W | Counter resolution |
| perf_ctl0 | input | DATA_W | Performance control register 0 |
| user_local | input | DATA_W | User-local register |
| req_valid | input | 1 | Read request strobe |
| req_num | input | 5 | Requested register number |
| req_sel | input | 3 | Select field |
| rsp_valid | output | 1 | Result valid |
| rsp_data | output | DATA_W | Read result |
| rsp_exc | output | 1 | Reserved-instruction exception |

## Verification
On every cycle, the assertions check four things. The response strobe follows the request strobe by one cycle. Exception results carry zero data. Unwritable grant bits stay zero. Grant bits 4 and 5 cannot be set without the required configuration. They also check the fixed exception cases for register 4 and 5 requests and the privileged read grant. Only the bench scenarios can show the right source value for each register number, the sign extension of the counter, and the interplay between writes to the grant register and user-mode permission over changing configurations.

// File: rtl/hwreg_pkg.sv
package hwreg_pkg;
   localparam int unsigned NUM_W = 5;
   localparam int unsigned SEL_W = 3;
   localparam int unsigned GR_W  = 1 << NUM_W;

   typedef enum logic [NUM_W-1:0] {
      HR_CPUID = 5'd0,
      HR_STEP  = 5'd1,
      HR_CYCLE = 5'd2,
      HR_RES   = 5'd3,
      HR_PERF  = 5'd4,
      HR_CFGB  = 5'd5,
      HR_ULOC  = 5'd29
   } hwreg_id_e;

   localparam int unsigned BASE_BITS = 4;
endpackage

// File: rtl/hwreg_grant_reg.sv
module hwreg_grant_reg
   import hwreg_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [GR_W-1:0] wdata,
   input  logic            rev6,
   input  logic            perf_present,
   input  logic            uloc_present,
   output logic [GR_W-1:0] grant_q
);
   logic [GR_W-1:0] wmask;

   always_comb begin
      wmask                 = '0;
      wmask[BASE_BITS-1:0]  = '1;
      wmask[int'(HR_PERF)]  = perf_present & rev6;
      wmask[int'(HR_CFGB)]  = rev6;
      wmask[int'(HR_ULOC)]  = uloc_present;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  grant_q <= '0;
      else if (wr) grant_q <= wdata & wmask;
   end

   // R3
   unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q[GR_W-1:30] == '0) && (grant_q[28:6] == '0));

   // R2
   perf_bit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !(perf_present && rev6)) |=> !grant_q[int'(HR_PERF)]);

   // R2
   cfgb_bit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !rev6) |=> !grant_q[int'(HR_CFGB)]);
endmodule

// File: rtl/hwreg_source_mux.sv
module hwreg_source_mux
   import hwreg_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CPUNUM_W = 10,
   parameter int unsigned CFG_BIT  = 13
) (
   input  logic [NUM_W-1:0]  num,
   input  logic [SEL_W-1:0]  sel,
   input  logic              rev6,
   input  logic              priv,
   input  logic [GR_W-1:0]   grant,
   input  logic [DATA_W-1:0] ebase,
   input  logic [DATA_W-1:0] line_step,
   input  logic [31:0]       cycle_cnt,
   input  logic [DATA_W-1:0] cnt_res,
   input  logic [DATA_W-1:0] perf_ctl0,
   input  logic [DATA_W-1:0] user_local,
   input  logic [31:0]       cfg5_word,
   output logic [DATA_W-1:0] value,
   output logic              exc
);
   logic [DATA_W-1:0] cyc_ext;
   logic              known;
   logic              allowed;
   logic [DATA_W-1:0] raw;

   generate
      if (DATA_W > 32) begin : g_wide
         assign cyc_ext = {{(DATA_W-32){cycle_cnt[31]}}, cycle_cnt};
      end else begin : g_narrow
         assign cyc_ext = cycle_cnt;
      end
   endgenerate

   always_comb begin
      known = 1'b1;
      raw   = '0;
      unique case (num)
         HR_CPUID: raw = DATA_W'(ebase[CPUNUM_W-1:0]);
         HR_STEP:  raw = line_step;
         HR_CYCLE: raw = cyc_ext;
         HR_RES:   raw = cnt_res;
         HR_PERF: begin
            raw   = perf_ctl0;
            known = rev6 && (sel == '0);
         end
         HR_CFGB: begin
            raw   = DATA_W'(cfg5_word[CFG_BIT]);
            known = rev6;
         end
         HR_ULOC:  raw = user_local;
         default:  known = 1'b0;
      endcase
      allowed = known && (priv || grant[num]);
      exc     = !allowed;
      value   = allowed ? raw : '0;
   end
endmodule

// File: rtl/hwreg_user_read.sv
module hwreg_user_read
   import hwreg_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CPUNUM_W = 10,
   parameter int unsigned CFG_BIT  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv_mode,
   input  logic              isa_rev6,
   input  logic              cfg_perf_present,
   input  logic              cfg_uloc_present,
   input  logic [31:0]       cfg5_word,
   input  logic              gr_wr,
   input  logic [31:0]       gr_wdata,
   output logic [31:0]       gr_rdata,
   input  logic [DATA_W-1:0] ebase,
   input  logic [DATA_W-1:0] line_step,
   input  logic [31:0]       cycle_cnt,
   input  logic [DATA_W-1:0] cnt_res,
   input  logic [DATA_W-1:0] perf_ctl0,
   input  logic [DATA_W-1:0] user_local,
   input  logic              req_valid,
   input  logic [4:0]        req_num,
   input  logic [2:0]        req_sel,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_exc
);
   localparam int unsigned CFG_W = 32;

   generate
      if (DATA_W < 32) begin : g_bad_width
         $error("hwreg_user_read: DATA_W must be at least 32");
      end
      if (CPUNUM_W == 0 || CPUNUM_W > DATA_W) begin : g_bad_cpunum
         $error("hwreg_user_read: CPUNUM_W out of range");
      end
      if (CFG_BIT >= CFG_W) begin : g_bad_cfgbit
         $error("hwreg_user_read: CFG_BIT out of range");
      end
   endgenerate

   logic [GR_W-1:0]   grant_q;
   logic [DATA_W-1:0] mux_value;
   logic              mux_exc;

   hwreg_grant_reg u_grant (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (gr_wr),
      .wdata        (gr_wdata),
      .rev6         (isa_rev6),
      .perf_present (cfg_perf_present),
      .uloc_present (cfg_uloc_present),
      .grant_q      (grant_q)
   );

   hwreg_source_mux #(
      .DATA_W   (DATA_W),
      .CPUNUM_W (CPUNUM_W),
      .CFG_BIT  (CFG_BIT)
   ) u_mux (
      .num        (req_num),
      .sel        (req_sel),
      .rev6       (isa_rev6),
      .priv       (priv_mode),
      .grant      (grant_q),
      .ebase      (ebase),
      .line_step  (line_step),
      .cycle_cnt  (cycle_cnt),
      .cnt_res    (cnt_res),
      .perf_ctl0  (perf_ctl0),
      .user_local (user_local),
      .cfg5_word  (cfg5_word),
      .value      (mux_value),
      .exc        (mux_exc)
   );

   assign gr_rdata = grant_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_exc   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_data <= mux_value;
            rsp_exc  <= mux_exc;
         end
      end
   end

   // R12
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R12
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R12
   exc_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_exc) |-> (rsp_data == '0));

   // R8
   perf_sel_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_num == 5'd4 && req_sel != 3'd0) |=> rsp_exc);

   // R10
   old_isa_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !isa_rev6 && (req_num == 5'd4 || req_num == 5'd5)) |=> rsp_exc);

   // R4
   priv_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && priv_mode && req_num <= 5'd3) |=> !rsp_exc);
endmodule

// File: tb/hwreg_user_read_tb_top.sv
module hwreg_user_read_tb_top;
   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          priv_mode = 1'b0, isa_rev6 = 1'b0;
   logic          cfg_perf_present = 1'b0, cfg_uloc_present = 1'b0;
   logic [31:0]   cfg5_word = '0;
   logic          gr_wr = 1'b0;
   logic [31:0]   gr_wdata = '0;
   logic [31:0]   gr_rdata;
   logic [DW-1:0] ebase = '0, line_step = '0, cnt_res = '0, perf_ctl0 = '0, user_local = '0;
   logic [31:0]   cycle_cnt = '0;
   logic          req_valid = 1'b0;
   logic [4:0]    req_num = '0;
   logic [2:0]    req_sel = '0;
   logic          rsp_valid, rsp_exc;
   logic [DW-1:0] rsp_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [31:0] model_gr = '0;

   always #4 clk = ~clk;

   hwreg_user_read dut_i (.*);

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] wmask_of(input bit rev6, input bit perf, input bit uloc);
      logic [31:0] m = 32'h0000_000F;
      if (perf && rev6) m[4] = 1'b1;
      if (rev6)         m[5] = 1'b1;
      if (uloc)         m[29] = 1'b1;
      return m;
   endfunction

   // computes expected {exc, data} and the requirement tag
   task automatic expect_rsp(output bit e_exc, output logic [DW-1:0] e_data, output string tag);
      bit known = 1'b1;
      e_data = '0;
      case (req_num)
         5'd0:  begin e_data = {22'd0, ebase[9:0]}; tag = "R5"; end
         5'd1:  begin e_data = line_step; tag = "R6"; end
         5'd2:  begin e_data = cycle_cnt; tag = "R7"; end
         5'd3:  begin e_data = cnt_res; tag = "R6"; end
         5'd4:  begin
            e_data = perf_ctl0; tag = "R8";
            if (!isa_rev6) begin known = 1'b0; tag = "R10"; end
            else if (req_sel != 0) known = 1'b0;
         end
         5'd5:  begin
            e_data = {31'd0, cfg5_word[13]}; tag = "R9";
            if (!isa_rev6) begin known = 1'b0; tag = "R10"; end
         end
         5'd29: begin e_data = user_local; tag = "R11"; end
         default: begin known = 1'b0; tag = "R11"; end
      endcase
      if (known && !priv_mode && !model_gr[req_num]) tag = "R4";
      e_exc = !(known && (priv_mode || model_gr[req_num]));
      if (e_exc) e_data = '0;
   endtask

   // called right after a negedge with inputs already driven
   task automatic step();
      bit e_exc; logic [DW-1:0] e_data; string tag;
      bit had_req = req_valid;
      expect_rsp(e_exc, e_data, tag);
      if (gr_wr) model_gr = gr_wdata & wmask_of(isa_rev6, cfg_perf_present, cfg_uloc_present);
      @(negedge clk);
      check(rsp_valid == had_req, "R12", "rsp_valid", 64'(rsp_valid), 64'(had_req));
      if (had_req) begin
         check(rsp_exc == e_exc, tag, "rsp_exc", 64'(rsp_exc), 64'(e_exc));
         check(rsp_data == e_data, tag, "rsp_data", 64'(rsp_data), 64'(e_data));
      end
      check(gr_rdata == model_gr, "R1/R2/R3", "grant", 64'(gr_rdata), 64'(model_gr));
      req_valid = 1'b0;
      gr_wr = 1'b0;
   endtask

   task automatic do_req(input logic [4:0] n, input logic [2:0] s);
      req_valid = 1'b1; req_num = n; req_sel = s;
      step();
   endtask

   task automatic do_write(input logic [31:0] v);
      gr_wr = 1'b1; gr_wdata = v;
      step();
   endtask

   task automatic randomize_sources();
      ebase = $urandom; line_step = $urandom; cycle_cnt = $urandom;
      cnt_res = $urandom; perf_ctl0 = $urandom; user_local = $urandom;
      cfg5_word = $urandom;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(gr_rdata == 32'h0, "R1", "grant after reset", 64'(gr_rdata), 64'h0);
      check(rsp_valid == 1'b0, "R12", "rsp_valid after reset", 64'(rsp_valid), 64'h0);

      // directed: mask with all options on, then off
      isa_rev6 = 1; cfg_perf_present = 1; cfg_uloc_present = 1;
      do_write(32'hFFFF_FFFF);                       // R2 R3 expect 2000003F
      check(gr_rdata == 32'h2000_003F, "R2", "full mask", 64'(gr_rdata), 64'h2000003F);
      isa_rev6 = 0; cfg_perf_present = 1; cfg_uloc_present = 0;
      do_write(32'hFFFF_FFFF);                       // R1 only base bits
      check(gr_rdata == 32'h0000_000F, "R1", "base mask", 64'(gr_rdata), 64'hF);

      // directed reads
      randomize_sources();
      cycle_cnt = 32'h8000_0001;                     // R7 sign bit set
      ebase = 32'hFFFF_FFFF;                         // R5 masks to 3FF
      priv_mode = 0;
      do_req(5'd0, 3'd5);                            // R5, sel ignored
      do_req(5'd2, 3'd0);                            // R7
      do_req(5'd4, 3'd0);                            // R10 old core
      do_req(5'd5, 3'd0);                            // R10
      isa_rev6 = 1; priv_mode = 1;
      do_req(5'd4, 3'd1);                            // R8 nonzero sel faults even privileged
      do_req(5'd4, 3'd0);                            // R8
      cfg5_word = 32'h0000_2000;
      do_req(5'd5, 3'd0);                            // R9 -> 1
      do_req(5'd29, 3'd0);                           // R11
      do_req(5'd17, 3'd0);                           // R11 unknown
      priv_mode = 0;
      do_req(5'd29, 3'd0);                           // R4 no grant
      do_req(5'd1, 3'd0);                            // R6 granted via base bits

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         int pick = $urandom_range(0, 9);
         isa_rev6 = ($urandom_range(0, 3) != 0);
         cfg_perf_present = $urandom_range(0, 1);
         cfg_uloc_present = $urandom_range(0, 1);
         priv_mode = ($urandom_range(0, 3) == 0);
         randomize_sources();
         if ($urandom_range(0, 4) == 0) begin
            gr_wr = 1'b1; gr_wdata = $urandom;
         end
         if ($urandom_range(0, 5) != 0) begin
            req_valid = 1'b1;
            req_num = (pick < 6) ? 5'(pick) : (pick < 8) ? 5'd29 : 5'($urandom_range(0, 31));
            req_sel = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'd0;
         end
         step();
      end
      finish_run();
   end
endmodule